// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate

This block decides when a divided clock may appear on an output pin. The divided clock comes from a prescaler in the master-clock domain. Two sources can enable the output: a hardware pin and a control-register bit. The output is held low until a start-up count of master-clock cycles has elapsed after reset. The gate opens and closes only while the divided clock is low, so every pulse on the pin is as wide as a high phase of the divided clock. The first pulse after an enable also comes at a fixed distance from the divided clock's own rising edge.

A power-down request goes through a filter before it has any effect. The request must stay asserted for a minimum number of master cycles, and two rising edges of the divided clock must be seen during that time. Once the request is accepted, the oscillator-run flag drops and the output is forced low. When the request is withdrawn, the flag rises again and the start-up count runs from zero before the output may turn on.

Top module: `clk_out_gate`

## Requirements
- R1: While reset is asserted and right after it, `clk_o` is low and `osc_run_o` is high.
- R2: `clk_o` stays low for the first STARTUP_CYCLES (default 512) master cycles after reset is released, whatever the enables are.
- R3: The effective enable is `en_pin_i` OR `en_bit_i`. Either input alone brings pulses onto `clk_o`. With both low, `clk_o` is low once any pulse in progress has finished.
- R4: Every high pulse on `clk_o` lasts exactly as long as a high phase of `div_clk_i`. A pulse is never cut short or partial, at enable or at disable (power-down excepted).
- R5: Each pulse on `clk_o` lags `div_clk_i` by two master cycles. After `en_pin_i` rises, the first pulse is the copy of the first `div_clk_i` rise that comes two or more master cycles later. Earlier rises are skipped whole.
- R6: When the effective enable falls during a pulse, that pulse completes at full width and `clk_o` then stays low.
- R7: A `pdn_i` request that lasts fewer than DEGLITCH_CYCLES master cycles is ignored. `osc_run_o` stays high and pulses on `clk_o` continue.
- R8: A `pdn_i` request is accepted only when it has been held for at least DEGLITCH_CYCLES master cycles and two `div_clk_i` rising edges have been seen in that time. Acceptance drives `osc_run_o` low and holds `clk_o` low.
- R9: Once `pdn_i` is withdrawn, `osc_run_o` rises within a few cycles. `clk_o` then stays low for a fresh STARTUP_CYCLES count before pulses may resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mst_i | input | 1 | Master clock |
| rst_an_i | input | 1 | Asynchronous reset, active low |
| div_clk_i | input | 1 | Prescaled clock, generated in the master-clock domain |
| en_pin_i | input | 1 | Asynchronous hardware enable, active high |
| en_bit_i | input | 1 | Software enable bit from a master-domain register |
| pdn_i | input | 1 | Asynchronous power-down request, active high |
| clk_o | output | 1 | Gated clock output, low when disabled |
| osc_run_o | output | 1 | High while the oscillator is allowed to run |

## Verification
The two functions that can land in the same master cycle are the change of the gate and a transition of the divided clock. An enable or disable can arrive right beside a rising edge of `div_clk_i`. A power-down acceptance can also fall in the middle of a high phase. The bench sweeps the phase at which `en_pin_i` rises across the divided-clock period and predicts which rising edge the first pulse must copy. A second sweep drops the enable while a pulse is on the pin. A width monitor runs throughout and judges every completed pulse against the divided clock's high phase, so one truncated or stretched pulse counts as a failure.

// File: rtl/cgate_pkg.sv
package cgate_pkg;
   typedef enum logic {
      GATE_SHUT = 1'b0,
      GATE_OPEN = 1'b1
   } gate_e;
endpackage

// File: rtl/cgate_sync.sv
module cgate_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cgate_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cgate_startup.sv
module cgate_startup #(
   parameter int COUNT = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic ready
);
   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] LAST = CW'(COUNT);

   generate
      if (COUNT < 1) begin : g_bad_count
         $error("cgate_startup: COUNT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (hold)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign ready = (cnt == LAST);

   AST_HOLD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !ready); // R9
endmodule

// File: rtl/cgate_pd_filter.sv
module cgate_pd_filter #(
   parameter int HOLD_CYCLES = 500,
   parameter int MIN_EDGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   input  logic div_rise,
   output logic pd_q,
   output logic accept
);
   localparam int CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES);

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("cgate_pd_filter: HOLD_CYCLES must be at least 1");
      end
      if (MIN_EDGES < 0) begin : g_bad_edges
         $error("cgate_pd_filter: MIN_EDGES must not be negative");
      end
   endgenerate

   logic [CW-1:0] hold_cnt;
   logic          hold_ok;
   logic          edges_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        hold_cnt <= '0;
      else if (!req_s)                   hold_cnt <= '0;
      else if (hold_cnt != HOLD_LAST)    hold_cnt <= hold_cnt + 1'b1;
   end

   assign hold_ok = (hold_cnt == HOLD_LAST);

   generate
      if (MIN_EDGES > 0) begin : g_edge_count
         localparam int EW = $clog2(MIN_EDGES + 1);
         localparam logic [EW-1:0] EDGE_LAST = EW'(MIN_EDGES);
         logic [EW-1:0] edge_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                edge_cnt <= '0;
            else if (!req_s)                           edge_cnt <= '0;
            else if (div_rise && edge_cnt != EDGE_LAST) edge_cnt <= edge_cnt + 1'b1;
         end

         assign edges_ok = (edge_cnt == EDGE_LAST);
      end else begin : g_no_edge_count
         assign edges_ok = 1'b1;
      end
   endgenerate

   assign accept = req_s & hold_ok & edges_ok & ~pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pd_q <= 1'b0;
      else if (!req_s) pd_q <= 1'b0;
      else if (accept) pd_q <= 1'b1;
   end

   AST_PD_ONLY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_q) |-> $past(req_s)); // R8
endmodule

// File: rtl/cgate_core.sv
module cgate_core
   import cgate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic div_q,
   input  logic want,
   input  logic force_off,
   output logic clk_o
);
   gate_e gate_q;
   logic  out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gate_q <= GATE_SHUT;
      else if (force_off) gate_q <= GATE_SHUT;
      else if (!div_q)    gate_q <= gate_e'(want);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= !force_off && (gate_q == GATE_OPEN) && div_q;
   end

   assign clk_o = out_q;

   AST_GATE_MOVES_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_q) |-> ($past(!div_q) || $past(force_off))); // R4
   AST_OUT_ONLY_ON_DIV_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |-> $past(div_q)); // R4
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate #(
   parameter int STARTUP_CYCLES  = 512,
   parameter int DEGLITCH_CYCLES = 500,
   parameter int MIN_DIV_EDGES   = 2,
   parameter int SYNC_STAGES     = 2
) (
   input  logic clk_mst_i,
   input  logic rst_an_i,
   input  logic div_clk_i,
   input  logic en_pin_i,
   input  logic en_bit_i,
   input  logic pdn_i,
   output logic clk_o,
   output logic osc_run_o
);
   logic div_q, div_d, div_rise;
   logic en_pin_s, pdn_s;
   logic ready, pd_q, pd_accept;
   logic want, force_off;

   always_ff @(posedge clk_mst_i or negedge rst_an_i) begin
      if (!rst_an_i) begin
         div_q <= 1'b0;
         div_d <= 1'b0;
      end else begin
         div_q <= div_clk_i;
         div_d <= div_q;
      end
   end

   assign div_rise = div_q & ~div_d;

   cgate_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_mst_i),
      .rst_n (rst_an_i),
      .d     ({pdn_i, en_pin_i}),
      .q     ({pdn_s, en_pin_s})
   );

   cgate_pd_filter #(.HOLD_CYCLES(DEGLITCH_CYCLES), .MIN_EDGES(MIN_DIV_EDGES)) u_pd (
      .clk      (clk_mst_i),
      .rst_n    (rst_an_i),
      .req_s    (pdn_s),
      .div_rise (div_rise),
      .pd_q     (pd_q),
      .accept   (pd_accept)
   );

   cgate_startup #(.COUNT(STARTUP_CYCLES)) u_start (
      .clk   (clk_mst_i),
      .rst_n (rst_an_i),
      .hold  (pd_q),
      .ready (ready)
   );

   assign want      = en_pin_s | en_bit_i;
   assign force_off = ~ready | pd_q | pd_accept;

   cgate_core u_core (
      .clk       (clk_mst_i),
      .rst_n     (rst_an_i),
      .div_q     (div_q),
      .want      (want),
      .force_off (force_off),
      .clk_o     (clk_o)
   );

   assign osc_run_o = ~pd_q;

   AST_OFF_IN_POWERDOWN: assert property (@(posedge clk_mst_i) disable iff (!rst_an_i)
      !osc_run_o |-> !clk_o); // R8
   AST_OFF_DURING_STARTUP: assert property (@(posedge clk_mst_i) disable iff (!rst_an_i)
      !ready |-> !clk_o); // R2
endmodule

// File: tb/clk_out_gate_bench.sv
module clk_out_gate_bench;
   localparam int STARTUP = 512;
   localparam int DEGL    = 500;
   localparam int PER     = 8;
   localparam int HALF    = 4;

   logic clk = 1'b0, rst_n = 1'b0, div = 1'b0;
   logic en_pin = 1'b0, en_bit = 1'b0, pdn = 1'b0;
   logic clk_o, run;
   int   phase = 0;
   bit   freeze = 1'b0, mon_en = 1'b0;
   int   run_len = 0, checks = 0, fails = 0;

   always #10 clk = ~clk;

   clk_out_gate u_clk_out_gate (
      .clk_mst_i (clk), .rst_an_i (rst_n), .div_clk_i (div),
      .en_pin_i (en_pin), .en_bit_i (en_bit), .pdn_i (pdn),
      .clk_o (clk_o), .osc_run_o (run)
   );

   always @(negedge clk) begin
      if (freeze) div <= 1'b0;
      else begin
         phase <= (phase + 1) % PER;
         div   <= ((phase + 1) % PER) >= HALF;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // R4: every completed high pulse has the divided clock's high width
   always @(negedge clk) begin
      #1;
      if (clk_o) run_len++;
      else begin
         if (run_len != 0 && mon_en) check(run_len == HALF, "R4 pulse width", run_len, HALF);
         run_len = 0;
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic expect_pulse(input string req, input int window);
      int seen = 0;
      for (int i = 0; i < window; i++) begin step(1); if (clk_o) seen = 1; end
      check(seen == 1, req, seen, 1);
   endtask

   task automatic expect_low(input string req, input int window);
      int highs = 0;
      for (int i = 0; i < window; i++) begin step(1); if (clk_o) highs++; end
      check(highs == 0, req, highs, 0);
   endtask

   task automatic t_reset;
      step(3);
      check(clk_o == 1'b0, "R1 clk_o in reset", clk_o, 0);
      check(run == 1'b1, "R1 run in reset", run, 1);
   endtask

   task automatic t_startup;
      en_pin = 1'b1;
      rst_n  = 1'b1;
      expect_low("R2 low during start-up", STARTUP);
      mon_en = 1'b1;
      expect_pulse("R2 pulses after start-up", 40);
   endtask

   task automatic t_or_enable;
      en_bit = 1'b1; en_pin = 1'b0;
      step(30);
      expect_pulse("R3 bit alone enables", 16);
      en_bit = 1'b0;
      step(20);
      expect_low("R3 neither enable", 16);
      en_pin = 1'b1;
      step(20);
      expect_pulse("R3 pin alone enables", 16);
   endtask

   task automatic t_latency(input int p);
      int tt, t_exp, t_got;
      en_pin = 1'b0; en_bit = 1'b0;
      step(24);
      while (phase != p) step(1);
      en_pin = 1'b1;
      tt = 2;
      while ((p + tt) % PER != HALF) tt++;
      t_exp = tt + 2;
      t_got = -1;
      for (int t = 1; t <= 24; t++) begin
         step(1);
         if (clk_o && t_got < 0) t_got = t;
      end
      check(t_got == t_exp, "R5 first pulse latency", t_got, t_exp);
   endtask

   task automatic t_disable_mid_pulse;
      en_pin = 1'b1;
      step(20);
      while (!clk_o) step(1);
      en_pin = 1'b0;
      step(24);
      expect_low("R6 low after disable", 16);
      en_pin = 1'b1;
      step(24);
   endtask

   task automatic t_short_pd;
      int drops = 0;
      pdn = 1'b1;
      for (int i = 0; i < DEGL / 2; i++) begin step(1); if (!run) drops++; end
      pdn = 1'b0;
      for (int i = 0; i < 20; i++) begin step(1); if (!run) drops++; end
      check(drops == 0, "R7 short request ignored", drops, 0);
      expect_pulse("R7 output continues", 16);
   endtask

   task automatic t_long_pd;
      mon_en = 1'b0;
      freeze = 1'b1;
      pdn    = 1'b1;
      step(DEGL + 40);
      check(run == 1'b1, "R8 needs divided-clock edges", run, 1);
      freeze = 1'b0;
      step(3 * PER + 8);
      check(run == 1'b0, "R8 accepted request", run, 0);
      expect_low("R8 output off in power-down", 40);
   endtask

   task automatic t_pd_release;
      pdn = 1'b0;
      mon_en = 1'b1;
      step(5);
      check(run == 1'b1, "R9 run restored", run, 1);
      expect_low("R9 start-up restarted", STARTUP - 5);
      expect_pulse("R9 pulses after restart", 40);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
   end

   initial begin
      t_reset();
      t_startup();
      t_or_enable();
      t_latency(0);
      t_latency(1);
      t_latency(3);
      t_latency(5);
      t_latency(6);
      t_disable_mid_pulse();
      t_short_pd();
      t_long_pd();
      t_pd_release();
      report();
      $finish;
   end
endmodule